// File: doc/BRIEF.md
# Single-track 1-of-N buffer stage

This block is a clocked model of a full-buffer pipeline stage whose neighbours speak to it over single-track channels. A channel is a group of N wires, held in a small register, that carries one token coded one-hot: wire i high means value i, and all wires low means the channel is empty. Whoever sends a token sets one wire. Whoever receives it clears the whole group. No separate acknowledge wire runs between neighbours.

The stage watches its left channel. When that channel holds a well-formed token and its right channel is empty, the stage registers a set strobe for the right channel. In that same cycle it raises an internal acknowledge that clears the left channel. While any right wire stays high, a busy condition stops the stage from moving anything else. A new left token can therefore wait beside an older token still waiting on the right, which gives the stage a slack of one. A left channel that shows more than one high wire is reported on an error output, cleared and not forwarded.

The top module holds both channel registers, the stage control and a reset synchronizer. The left sender drives a set vector. The right receiver drives a consume strobe.

Top module: `st_token_stage`

## Requirements
- R1: While `rst_n` is low, both channels read all zero and `ack` is 1. Once `rst_n` has been high for four clock edges, `ack` is 0 and both channels are still empty.
- R2: A nonzero `src_set` held during one cycle appears on `left_wires` at the next rising edge. Bit i of a channel is the wire for token value i.
- R3: Suppose a one-hot token appears on `left_wires` at edge E0 and the right channel is empty. Then `ack` is 1 after E1, and `right_wires` is still zero after E1. The token appears unchanged on `right_wires` at edge E2.
- R4: The left channel is cleared at the same edge E2 at which the token reaches the right channel, and `ack` is back to 0 after E2. `ack` is never high for two cycles in a row.
- R5: While `right_wires` is nonzero, `busy` is 1 and the stage sends no token to the right. A waiting left token stays on `left_wires`.
- R6: A token can wait on the left while a different token waits on the right. Suppose a consume at edge Ec empties the right channel. Then the waiting left token appears on the right at edge Ec+2, and the left channel clears at that same edge.
- R7: `sink_consume` held during one cycle clears every right wire at the next edge, and `busy` then reads 0.
- R8: Suppose `left_wires` shows two or more high wires at edge E0. Then `token_err` is 1 for exactly the one cycle after E1, the left channel is cleared at E2, and `right_wires` does not change. This holds whether the right channel is empty or busy.
- R9: Every token value 0 to N-1 (N defaults to 4) passes through the stage with its one-hot position preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_set | input | N | Left sender's set strobe, one bit per wire |
| sink_consume | input | 1 | Right receiver's strobe that clears the right channel |
| left_wires | output | N | Current state of the left channel |
| right_wires | output | N | Current state of the right channel (the forwarded token) |
| ack | output | 1 | Stage acknowledge, which clears the left channel |
| busy | output | 1 | High while any right wire is high |
| token_err | output | 1 | One-cycle flag for a left token with more than one wire high |

## Verification
A set strobe shows up on the left channel one edge after it is driven. The acknowledge follows one edge later. The forwarded token and the cleared left channel arrive together at the second edge. A consume takes effect at the next edge, and a token that was waiting is forwarded two edges after that. The error flag is high only during the cycle between the first and second edges after a malformed token appears. Each scenario task drives its inputs at a falling edge and samples at the falling edge that follows exactly the number of rising edges listed above. In this way every check confirms both the value and the cycle in which it appears, including the cycles in which nothing may have changed yet.

// File: rtl/st_buf_pkg.sv
package st_buf_pkg;

  typedef enum logic [1:0] {
    STG_INIT = 2'd0,
    STG_WAIT = 2'd1,
    STG_PUSH = 2'd2,
    STG_DROP = 2'd3
  } stg_state_t;

endpackage

// File: rtl/st_rst_sync.sv
module st_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/st_chan_reg.sv
module st_chan_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] line_o
);

  logic [N-1:0] line_q;
  logic [N-1:0] line_d;
  logic         line_en;

  // next state: a clear empties the group, a set raises its wires
  always_comb begin
    line_en = clr_i | (|set_i);
    line_d  = (clr_i ? '0 : line_q) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (line_en) begin
      line_q <= line_d;
    end
  end

  assign line_o = line_q;

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(|set_i)) |=> (line_o == '0));

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set_i) && !clr_i) |=> ((line_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/st_stage_ctrl.sv
module st_stage_ctrl
  import st_buf_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] left_i,
  input  logic [N-1:0] right_i,
  output logic [N-1:0] fwd_set_o,
  output logic         ack_o,
  output logic         busy_o,
  output logic         err_o
);

  localparam int CW = $clog2(N + 1);

  stg_state_t   state_q, state_d;
  logic [N-1:0] tok_q, tok_d;
  logic         tok_en;
  logic [CW-1:0] left_cnt;
  logic         left_ok;
  logic         left_bad;

  // left completion: count high wires
  always_comb begin
    left_cnt = '0;
    for (int i = 0; i < N; i++) begin
      left_cnt = left_cnt + CW'(left_i[i]);
    end
    left_ok  = (left_cnt == CW'(1));
    left_bad = (left_cnt > CW'(1));
  end

  // right completion: any high output wire blocks the stage
  assign busy_o = |right_i;

  // next-state logic
  always_comb begin
    state_d = state_q;
    tok_d   = '0;
    tok_en  = 1'b0;
    unique case (state_q)
      STG_INIT: state_d = STG_WAIT;
      STG_WAIT: begin
        if (left_bad) begin
          state_d = STG_DROP;
        end else if (left_ok && !busy_o) begin
          state_d = STG_PUSH;
          tok_d   = left_i;
          tok_en  = 1'b1;
        end
      end
      STG_PUSH: begin
        state_d = STG_WAIT;
        tok_en  = 1'b1;
      end
      STG_DROP: state_d = STG_WAIT;
      default:  state_d = STG_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= STG_INIT;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= '0;
    end else if (tok_en) begin
      tok_q <= tok_d;
    end
  end

  assign fwd_set_o = tok_q;
  assign ack_o     = (state_q != STG_WAIT);
  assign err_o     = (state_q == STG_DROP);

  // R4
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  // R5
  hold_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (fwd_set_o == '0));

  // R3
  fwd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fwd_set_o));

  // R8
  drop_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (fwd_set_o == '0));

  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

endmodule

// File: rtl/st_token_stage.sv
module st_token_stage #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_set,
  input  logic         sink_consume,
  output logic [N-1:0] left_wires,
  output logic [N-1:0] right_wires,
  output logic         ack,
  output logic         busy,
  output logic         token_err
);

  logic         rst_int_n;
  logic [N-1:0] fwd_set;
  logic         ack_int;

  st_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  st_chan_reg #(.N(N)) u_left (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (src_set),
    .clr_i  (ack_int),
    .line_o (left_wires)
  );

  st_stage_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .left_i    (left_wires),
    .right_i   (right_wires),
    .fwd_set_o (fwd_set),
    .ack_o     (ack_int),
    .busy_o    (busy),
    .err_o     (token_err)
  );

  st_chan_reg #(.N(N)) u_right (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (fwd_set),
    .clr_i  (sink_consume),
    .line_o (right_wires)
  );

  assign ack = ack_int;

  // R6
  fwd_into_empty_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fwd_set != '0) |-> (right_wires == '0));

endmodule

// File: tb/st_token_stage_test.sv
module st_token_stage_test;

  localparam int N = 4;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] src_set;
  logic         sink_consume;
  logic [N-1:0] left_wires;
  logic [N-1:0] right_wires;
  logic         ack;
  logic         busy;
  logic         token_err;

  int total_cnt;
  int fail_cnt;
  int cyc;

  st_token_stage #(.N(N)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_set      (src_set),
    .sink_consume (sink_consume),
    .left_wires   (left_wires),
    .right_wires  (right_wires),
    .ack          (ack),
    .busy         (busy),
    .token_err    (token_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      total_cnt = total_cnt + 1;
      fail_cnt  = fail_cnt + 1;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", total_cnt - fail_cnt, total_cnt);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total_cnt = total_cnt + 1;
    if (act !== exp) begin
      fail_cnt = fail_cnt + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [N-1:0] v);
    @(negedge clk) src_set = v;
    @(negedge clk) src_set = '0;
  endtask

  task automatic consume();
    @(negedge clk) sink_consume = 1'b1;
    @(negedge clk) sink_consume = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", 32'(ack), 32'd1);
    chk("R1 left empty in reset", 32'(left_wires), 32'd0);
    chk("R1 right empty in reset", 32'(right_wires), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ack released", 32'(ack), 32'd0);
    chk("R1 channels empty", 32'({left_wires, right_wires}), 32'd0);
  endtask

  task automatic t_forward(input int val);
    logic [N-1:0] tok;
    tok = N'(1) << val;
    send(tok);
    chk("R2 left set", 32'(left_wires), 32'(tok));
    @(negedge clk);
    chk("R3 ack after E1", 32'(ack), 32'd1);
    chk("R3 right not early", 32'(right_wires), 32'd0);
    @(negedge clk);
    chk("R9 right token", 32'(right_wires), 32'(tok));
    chk("R4 left cleared", 32'(left_wires), 32'd0);
    chk("R4 ack dropped", 32'(ack), 32'd0);
    chk("R5 busy high", 32'(busy), 32'd1);
    consume();
    chk("R7 right cleared", 32'(right_wires), 32'd0);
    chk("R7 busy low", 32'(busy), 32'd0);
  endtask

  task automatic t_slack();
    send(4'b0010);
    repeat (2) @(negedge clk);
    chk("R3 first token out", 32'(right_wires), 32'h2);
    send(4'b1000);
    repeat (5) @(negedge clk);
    chk("R5 left waits", 32'(left_wires), 32'h8);
    chk("R6 right held", 32'(right_wires), 32'h2);
    chk("R5 no ack while busy", 32'(ack), 32'd0);
    consume();
    chk("R6 right emptied", 32'(right_wires), 32'd0);
    chk("R6 left still waiting", 32'(left_wires), 32'h8);
    @(negedge clk);
    chk("R6 ack after Ec+1", 32'(ack), 32'd1);
    @(negedge clk);
    chk("R6 second token out", 32'(right_wires), 32'h8);
    chk("R6 left cleared", 32'(left_wires), 32'd0);
    consume();
  endtask

  task automatic t_multi();
    send(4'b0101);
    chk("R8 no err at E0", 32'(token_err), 32'd0);
    @(negedge clk);
    chk("R8 err after E1", 32'(token_err), 32'd1);
    @(negedge clk);
    chk("R8 err one cycle", 32'(token_err), 32'd0);
    chk("R8 left dropped", 32'(left_wires), 32'd0);
    chk("R8 right untouched", 32'(right_wires), 32'd0);
    repeat (2) @(negedge clk);
    chk("R8 nothing forwarded", 32'(right_wires), 32'd0);
    send(4'b0001);
    repeat (2) @(negedge clk);
    send(4'b1110);
    @(negedge clk);
    chk("R8 err while busy", 32'(token_err), 32'd1);
    @(negedge clk);
    chk("R8 busy left dropped", 32'(left_wires), 32'd0);
    chk("R8 busy right kept", 32'(right_wires), 32'h1);
    consume();
  endtask

  initial begin
    total_cnt    = 0;
    fail_cnt     = 0;
    cyc          = 0;
    src_set      = '0;
    sink_consume = 1'b0;
    rst_n        = 1'b0;
    t_reset();
    for (int v = 0; v < N; v++) t_forward(v);
    t_slack();
    t_multi();
    t_forward(2);
    $display("%0d/%0d checks passed", total_cnt - fail_cnt, total_cnt);
    $finish;
  end

endmodule